// File: doc/BRIEF.md
# Per-Channel Output Enable Serializer

This block turns per-channel output-enable bits, held in an external connection memory, into four serial control lines. External stream buffers use these lines to decide, channel by channel, whether each of 32 time-division-multiplexed output streams is driven or left at high impedance. The control lines always shift one bit per clock period, whatever rate each data stream runs at. A stream slower than the line rate has its enable bit repeated across the periods its channel spans.

An 11-bit period counter numbers the 2048 periods of a frame. A frame-pulse input realigns it. Each period, every line carries the bit of exactly one stream. Stream n uses line n mod 4 and a fixed phase inside each 8-period group. That phase is set by a per-stream lead, so the bit for channel 0 lands a few periods before the frame boundary.

The block reads the memory combinationally, one period ahead, with one address per line. It registers the returned bits onto the lines. It also keeps a per-stream high-impedance flag for the internal stream drivers. That flag follows the stream's most recently sent enable bit.

Top module: `oe_serializer`

## Requirements
- R1: While rst_ni is low, ctl_o is 0000, hiz_o is all ones and the period count is 0. The first clock edge after release starts period 1.
- R2: The period count advances by one at each clock edge and wraps from 2047 to 0. A cycle with fp_i high makes the next period 0, and that period's bits are already correct.
- R3: Stream n appears only on line ctl_o[n mod 4], and at most one stream per line is served in a period.
- R4: Write stream n as 4j + l, where l is the line and j runs from 0 to 7. The lead for j = 0 through 7 is 10, 8, 7, 6, 5, 4, 9, 3 periods. The stream's bit is sent in period p exactly when (p + lead) mod 8 = 0.
- R5: The bit sent in period p belongs to channel ((p + lead) mod 2048) / 8, shifted right by the stream's rate code k. The code is rate_i[2n+1:2n]: 0 means 16.384, 1 means 8.192, 2 means 4.096 and 3 means 2.048 Mb/s. Each bit is therefore sent 1, 2, 4 or 8 times.
- R6: Field mem_addr_o[11l+10:11l] = {j[2:0], channel[7:0]} addresses the bit for line l in the coming period. mem_data_i[l] is taken at the clock edge and appears on ctl_o[l] for the whole of that period.
- R7: In the period a stream's bit is on its line, hiz_o[n] equals the inverse of that bit. The flag holds that value until the stream's next slot.
- R8: The placement matches these cases:
  - Stream 4 at code 3 sends its channel-0 bit in periods 2040, 0, 8, 16, 24, 32, 40 and 48.
  - Stream 8 at code 1 sends its channel-1 bit in periods 9 and 17.
  - Stream 0 at code 0 sends its channel-0 bit in period 2038.
  - Streams 28 to 31 send their channel-0 bits in period 2045, on lines 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-rate clock, one period per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse; the next period becomes 0 |
| rate_i | input | 64 | Two-bit rate code per stream |
| mem_addr_o | output | 44 | Four read addresses {j, channel}, one per line |
| mem_data_i | input | 4 | Enable bits returned for the four addresses |
| ctl_o | output | 4 | Serial control lines |
| hiz_o | output | 32 | Per-stream high-impedance flag |

## Verification
The bench builds the block with its default 11-bit frame count, a 2048-period frame. With that setting, a single run covers the natural wrap and the placements that straddle the frame boundary, including the eight repeats of a slow stream that run from period 2040 through 48. The bench drives uniform, mixed and random rate settings over random enable patterns and checks every line and flag in every period. It then realigns the frame mid-way and checks the stated placement cases one by one.

// File: rtl/oe_serializer.sv
module oe_serializer #(
  parameter int FRAME_BITS = 11,
  localparam int CH_W = FRAME_BITS - 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fp_i,
  input  logic [63:0]             rate_i,
  output logic [4*FRAME_BITS-1:0] mem_addr_o,
  input  logic [3:0]              mem_data_i,
  output logic [3:0]              ctl_o,
  output logic [31:0]             hiz_o
);

  function automatic logic [3:0] lead_of(input logic [2:0] j);
    case (j)
      3'd0: lead_of = 4'd10;
      3'd1: lead_of = 4'd8;
      3'd2: lead_of = 4'd7;
      3'd3: lead_of = 4'd6;
      3'd4: lead_of = 4'd5;
      3'd5: lead_of = 4'd4;
      3'd6: lead_of = 4'd9;
      default: lead_of = 4'd3;
    endcase
  endfunction

  function automatic logic [2:0] owner_of(input logic [2:0] ph);
    logic [3:0] ld;
    owner_of = 3'd0;
    for (int j = 0; j < 8; j++) begin
      ld = lead_of(3'(j));
      if (3'(ph + ld[2:0]) == 3'd0) owner_of = 3'(j);
    end
  endfunction

  logic [FRAME_BITS-1:0] cnt, nxt, shifted;
  logic [2:0]            own;
  logic [CH_W-1:0]       grp;

  assign nxt     = fp_i ? '0 : cnt + 1'b1;
  assign own     = owner_of(nxt[2:0]);
  assign shifted = nxt + FRAME_BITS'(lead_of(own));
  assign grp     = shifted[FRAME_BITS-1:3];

  for (genvar l = 0; l < 4; l++) begin : g_line
    logic [1:0] code;
    assign code = rate_i[2*{own, 2'(l)} +: 2];
    assign mem_addr_o[l*FRAME_BITS +: FRAME_BITS] = {own, grp >> code};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      ctl_o <= '0;
      hiz_o <= '1;
    end else begin
      cnt   <= nxt;
      ctl_o <= mem_data_i;
      for (int l = 0; l < 4; l++) hiz_o[{own, 2'(l)}] <= ~mem_data_i[l];
    end
  end

endmodule

module oe_serializer_chk #(
  parameter int FRAME_BITS = 11
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    fp_i,
  input logic [63:0]             rate_i,
  input logic [4*FRAME_BITS-1:0] mem_addr_o,
  input logic [3:0]              ctl_o,
  input logic [31:0]             hiz_o,
  input logic [FRAME_BITS-1:0]   cnt
);
  localparam int CH_W = FRAME_BITS - 3;

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ctl_o == 4'd0 && hiz_o == '1));

  assert_frame_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (cnt == '0));

  assert_frame_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> (cnt == FRAME_BITS'($past(cnt) + 1'b1)));

  assert_one_per_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hiz_o ^ $past(hiz_o)) <= 4);

  for (genvar l = 0; l < 4; l++) begin : g_rng
    logic [2:0]      j;
    logic [CH_W-1:0] ch;
    logic [1:0]      k;
    assign j  = mem_addr_o[l*FRAME_BITS+CH_W +: 3];
    assign ch = mem_addr_o[l*FRAME_BITS +: CH_W];
    assign k  = rate_i[2*{j, 2'(l)} +: 2];
    assert_chan_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch >> (CH_W - int'(k))) == '0);
  end

  for (genvar n = 0; n < 32; n++) begin : g_hz
    assert_hiz_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hiz_o[n] != $past(hiz_o[n])) |-> (ctl_o[n%4] == !hiz_o[n]));
  end
endmodule

bind oe_serializer oe_serializer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .rate_i(rate_i),
  .mem_addr_o(mem_addr_o), .ctl_o(ctl_o), .hiz_o(hiz_o), .cnt(cnt)
);

// File: tb/sim_oe_serializer.sv
`timescale 1ns/1ps
module sim_oe_serializer;
  localparam int FB = 11;
  localparam int CW = 8;
  localparam int FL = 2048;
  localparam int LEAD [8] = '{10, 8, 7, 6, 5, 4, 9, 3};
  localparam logic [95:0] VEC [4] = '{
    {64'h0000_0000_0000_0000, 32'h1234_5678},
    {64'hFFFF_FFFF_FFFF_FFFF, 32'hA5A5_0F0F},
    {64'h1B1B_1B1B_E4E4_4E4E, 32'h0BAD_F00D},
    {64'h9C36_E1D2_4B87_5A0F, 32'h7777_1357}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fp;
  logic [63:0] rate;
  logic [4*FB-1:0] addr;
  logic [3:0] md, ctl;
  logic [31:0] hiz;
  logic [255:0] en [32];

  int total = 0, bad = 0, pc = 0;
  logic [31:0] mhz;
  bit done = 0;

  oe_serializer u0 (.clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .rate_i(rate),
    .mem_addr_o(addr), .mem_data_i(md), .ctl_o(ctl), .hiz_o(hiz));

  always_comb
    for (int l = 0; l < 4; l++)
      md[l] = en[4*int'(addr[l*FB+CW +: 3]) + l][addr[l*FB +: CW]];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s period=%0d actual=%h expected=%h", req, pc, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int p, input int l, output int n);
    int s, k;
    exp_bit = 1'b0;
    n = l;
    for (int j = 0; j < 8; j++)
      if ((p + LEAD[j]) % 8 == 0) begin
        n = 4*j + l;
        s = (p + LEAD[j]) % FL;
        k = int'(rate[2*n +: 2]);
        exp_bit = en[n][(s/8) >> k];
      end
  endfunction

  task automatic tick(input logic pulse);
    int n;
    logic e;
    fp = pulse;
    @(posedge clk);
    pc = pulse ? 0 : (pc + 1) % FL;
    @(negedge clk);
    fp = 1'b0;
    for (int l = 0; l < 4; l++) begin
      e = exp_bit(pc, l, n);
      chk("R3 R4 R5 R6 line bit", 64'(ctl[l]), 64'(e));
      mhz[n] = ~e;
    end
    chk("R7 hiz flags", 64'(hiz), 64'(mhz));
  endtask

  task automatic fill(input logic [31:0] seed);
    logic [31:0] x = seed;
    for (int n = 0; n < 32; n++)
      for (int c = 0; c < 256; c++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        en[n][c] = x[0];
      end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ctl in reset", 64'(ctl), 64'd0);
    chk("R1 hiz in reset", 64'(hiz), 64'hFFFF_FFFF);
    rst_n = 1'b1;
    pc = 0;
    mhz = '1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fp = 1'b0; rate = '0; rst_n = 1'b0;
    for (int n = 0; n < 32; n++) en[n] = '0;
    @(negedge clk);
    do_reset();

    for (int v = 0; v < 4; v++) begin
      rate = VEC[v][95:32];
      fill(VEC[v][31:0]);
      for (int t = 0; t < FL + 16; t++) tick(1'b0);
    end

    // R2: realign in mid-frame
    for (int t = 0; t < 700; t++) tick(1'b0);
    tick(1'b1);
    chk("R2 realign to period 0", 64'(pc), 64'd0);
    for (int t = 0; t < 20; t++) tick(1'b0);

    // R8: stated placements
    for (int n = 0; n < 32; n++) en[n] = '0;
    rate = '0;
    rate[2*4 +: 2] = 2'd3;
    rate[2*8 +: 2] = 2'd1;
    en[4][0] = 1'b1; en[8][1] = 1'b1; en[0][0] = 1'b1;
    for (int n = 28; n < 32; n++) en[n][0] = 1'b1;
    tick(1'b1);
    for (int t = 0; t < FL + 60; t++) begin
      logic e0, eo;
      tick(1'b0);
      e0 = (pc == 2040 || pc == 2038 || pc == 2045 || pc == 9 || pc == 17 ||
            (pc % 8 == 0 && pc <= 48));
      eo = (pc == 2045);
      chk("R8 line 0 placement", 64'(ctl[0]), 64'(e0));
      chk("R8 lines 1-3 placement", 64'(ctl[3:1]), eo ? 64'd7 : 64'd0);
    end

    do_reset();
    tick(1'b0);
    chk("R1 first period after release", 64'(pc), 64'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule